// File: doc/BRIEF.md
# Unaligned 16-bit Word Detector for Byte Streams

This block takes a stream of bytes, one per clock when the valid strobe is high, and finds a programmable 16-bit word that may start at any bit position in the stream, not only on byte edges. Every stream bit gets an absolute index. Byte k of the stream carries bits 8k to 8k+7, and bit 0 of each byte is the earliest bit in time. The block keeps the two bytes that came before the current one. With the current byte they form a 24-bit window. On each accepted byte it tests the eight 16-bit slices that start at offsets 0 to 7 inside that window. Across successive bytes these slices cover every possible start bit exactly once.

A hit raises a one-cycle pulse. Alongside it the block reports the absolute start bit of the lowest matching offset. For the latest step it also gives the start bit of candidate 0 and an eight-bit mask of the candidates that matched. A sticky register keeps the first match position until the search is restarted. A synchronous clear restarts the search, and so does loading a new pattern, which is allowed only while no bytes are being sent.

Top module: `bws_word_finder`

## Requirements
- R1: After reset, hit_o, first_vld_o and cand_hits_o are all zero.
- R2: After a reset, a clear or a pattern load, the first two accepted bytes never cause a hit. The first compare happens on the third byte, and hit_o for that byte appears one cycle later.
- R3: Stream bit order is LSB-first: bit b of byte k is stream bit 8k+b. Pattern bit i is compared with stream bit s+i for a candidate that starts at bit s.
- R4: A match starting at bit s is detected when byte number floor(s/8)+2 (counting from 0) is accepted. hit_o is high in the cycle after that byte is registered and lasts one cycle unless the next byte also hits.
- R5: hit_o is accompanied by hit_pos_o, the absolute start bit of the match. When several candidates of one step match, the lowest start bit is reported.
- R6: On every compare step, cand_base_o holds the start bit of candidate 0 of that step. Bit j of cand_hits_o is set exactly when the slice starting at cand_base_o+j equals the pattern.
- R7: first_vld_o rises with the first hit after a restart, with first_pos_o equal to that hit's position. Both then hold through later hits until the next clear or pattern load.
- R8: A clr_i pulse empties the window, zeroes the outputs and the sticky register, and restarts bit numbering so that the next accepted byte holds stream bits 0 to 7.
- R9: A pat_we_i pulse stores pat_i as the new pattern and restarts the search in the same way as a clear.
- R10: While byte_vld_i is low, byte_i is ignored. The window and the bit numbering do not change, and hit_o is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous restart of the search |
| pat_we_i | input | 1 | Store pat_i as the pattern and restart |
| pat_i | input | 16 | Pattern to search for, bit 0 earliest |
| byte_vld_i | input | 1 | byte_i carries a stream byte this cycle |
| byte_i | input | 8 | Stream byte, bit 0 earliest |
| hit_o | output | 1 | Match pulse for the last compare step |
| hit_pos_o | output | 32 | Start bit of the lowest match of that step |
| cand_base_o | output | 32 | Start bit of candidate 0 of the last step |
| cand_hits_o | output | 8 | Per-candidate match mask of the last step |
| first_vld_o | output | 1 | A match has been seen since the last restart |
| first_pos_o | output | 32 | Start bit of that first match |

## Verification
The checker assumes that reset, clr_i and pat_w_i are the only events that restart the fill count. Its own byte counter, which tracks when comparing may begin, relies on that. It also assumes pat_we_i never arrives in the same cycle as a stream byte, because the restart would silently drop that byte. The stimulus drives every input at the falling edge and keeps pattern loads, clears and bytes in separate cycles. It inserts idle cycles with a changing byte_i to show that unstrobed data has no effect.

// File: rtl/bws_pkg.sv
package bws_pkg;

    // Default geometry of the detector
    localparam int BWS_PAT_W  = 16;
    localparam int BWS_LANE_W = 8;
    localparam int BWS_POS_W  = 32;

    // Number of whole bytes of history needed before a full pattern fits
    function automatic int bws_fill_need(input int pat_w, input int lane_w);
        return (pat_w + lane_w - 1) / lane_w;
    endfunction

endpackage

// File: rtl/bws_slice_cmp.sv
// Compares every lane-offset slice of the window against the pattern
module bws_slice_cmp #(
    parameter int PAT_W  = 16,
    parameter int LANE_W = 8
) (
    input  logic [PAT_W+LANE_W-1:0] win_i,
    input  logic [PAT_W-1:0]        pat_i,
    output logic [LANE_W-1:0]       match_o
);
    localparam int NOFS = LANE_W;

    for (genvar j = 0; j < NOFS; j++) begin : g_slice
        assign match_o[j] = (win_i[j +: PAT_W] == pat_i);
    end

endmodule

// File: rtl/bws_prio_enc.sv
// Lowest-set-bit priority encoder
module bws_prio_enc #(
    parameter int N = 8
) (
    input  logic [N-1:0]                 req_i,
    output logic                         any_o,
    output logic [$clog2(N)-1:0]         idx_o
);
    localparam int IDX_W = $clog2(N);

    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int j = N - 1; j >= 0; j--) begin
            if (req_i[j]) begin
                idx_o = IDX_W'(j);
            end
        end
    end

endmodule

// File: rtl/bws_word_finder.sv
module bws_word_finder
    import bws_pkg::*;
#(
    parameter int PAT_W  = BWS_PAT_W,
    parameter int LANE_W = BWS_LANE_W,
    parameter int POS_W  = BWS_POS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              pat_we_i,
    input  logic [PAT_W-1:0]  pat_i,
    input  logic              byte_vld_i,
    input  logic [LANE_W-1:0] byte_i,
    output logic              hit_o,
    output logic [POS_W-1:0]  hit_pos_o,
    output logic [POS_W-1:0]  cand_base_o,
    output logic [LANE_W-1:0] cand_hits_o,
    output logic              first_vld_o,
    output logic [POS_W-1:0]  first_pos_o
);
    localparam int WIN_W     = PAT_W + LANE_W;
    localparam int NOFS      = LANE_W;
    localparam int OFS_W     = $clog2(NOFS);
    localparam int FILL_NEED = bws_fill_need(PAT_W, LANE_W);
    localparam int FILL_W    = $clog2(FILL_NEED + 1);
    localparam int HIST_W    = FILL_NEED * LANE_W;

    typedef struct packed {
        logic [PAT_W-1:0]  pat;
        logic [HIST_W-1:0] hist;
        logic [FILL_W-1:0] fill;
        logic [POS_W-1:0]  base;
        logic              hit;
        logic [POS_W-1:0]  hit_pos;
        logic [NOFS-1:0]   cand_hits;
        logic [POS_W-1:0]  cand_base;
        logic              first_vld;
        logic [POS_W-1:0]  first_pos;
    } bws_state_t;

    bws_state_t st_d, st_q;

    logic [WIN_W-1:0] win;
    logic [NOFS-1:0]  slice_match;
    logic             slice_any;
    logic [OFS_W-1:0] slice_idx;
    logic             armed;
    logic             restart;

    // Window: newest byte on top, older history below (LSB is earliest bit)
    assign win = WIN_W'({byte_i, st_q.hist});

    bws_slice_cmp #(
        .PAT_W  (PAT_W),
        .LANE_W (LANE_W)
    ) cmp_i (
        .win_i   (win),
        .pat_i   (st_q.pat),
        .match_o (slice_match)
    );

    bws_prio_enc #(
        .N (NOFS)
    ) enc_i (
        .req_i (slice_match),
        .any_o (slice_any),
        .idx_o (slice_idx)
    );

    assign armed   = (st_q.fill == FILL_W'(FILL_NEED));
    assign restart = clr_i | pat_we_i;

    always_comb begin
        st_d     = st_q;
        st_d.hit = 1'b0;
        if (restart) begin
            st_d.hist      = '0;
            st_d.fill      = '0;
            st_d.base      = '0;
            st_d.hit_pos   = '0;
            st_d.cand_hits = '0;
            st_d.cand_base = '0;
            st_d.first_vld = 1'b0;
            st_d.first_pos = '0;
            if (pat_we_i) begin
                st_d.pat = pat_i;
            end
        end else if (byte_vld_i) begin
            st_d.hist = win[WIN_W-1 -: HIST_W];
            if (armed) begin
                st_d.cand_hits = slice_match;
                st_d.cand_base = st_q.base;
                st_d.base      = st_q.base + POS_W'(LANE_W);
                st_d.hit       = slice_any;
                if (slice_any) begin
                    st_d.hit_pos = st_q.base + POS_W'(slice_idx);
                    if (!st_q.first_vld) begin
                        st_d.first_vld = 1'b1;
                        st_d.first_pos = st_q.base + POS_W'(slice_idx);
                    end
                end
            end else begin
                st_d.fill = st_q.fill + FILL_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hit_o       = st_q.hit;
    assign hit_pos_o   = st_q.hit_pos;
    assign cand_base_o = st_q.cand_base;
    assign cand_hits_o = st_q.cand_hits;
    assign first_vld_o = st_q.first_vld;
    assign first_pos_o = st_q.first_pos;

endmodule

// File: rtl/bws_chk.sv
module bws_chk
    import bws_pkg::*;
#(
    parameter int PAT_W  = BWS_PAT_W,
    parameter int LANE_W = BWS_LANE_W,
    parameter int POS_W  = BWS_POS_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr_i,
    input logic              pat_we_i,
    input logic              byte_vld_i,
    input logic              hit_o,
    input logic [POS_W-1:0]  hit_pos_o,
    input logic [POS_W-1:0]  cand_base_o,
    input logic [LANE_W-1:0] cand_hits_o,
    input logic              first_vld_o,
    input logic [POS_W-1:0]  first_pos_o
);
    localparam int NOFS      = LANE_W;
    localparam int OFS_W     = $clog2(NOFS);
    localparam int FILL_NEED = bws_fill_need(PAT_W, LANE_W);
    localparam int SEEN_W    = $clog2(FILL_NEED + 1);

    logic [SEEN_W-1:0] seen_q;
    logic [POS_W-1:0]  diff;
    logic [OFS_W-1:0]  diff_ofs;
    logic [NOFS-1:0]   below_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (clr_i || pat_we_i) begin
            seen_q <= '0;
        end else if (byte_vld_i && seen_q != SEEN_W'(FILL_NEED)) begin
            seen_q <= seen_q + SEEN_W'(1);
        end
    end

    always_comb begin
        diff       = hit_pos_o - cand_base_o;
        diff_ofs   = diff[OFS_W-1:0];
        below_mask = (NOFS'(1) << diff_ofs) - NOFS'(1);
    end

    // R2
    early_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_i && !clr_i && !pat_we_i && seen_q != SEEN_W'(FILL_NEED)) |=> !hit_o);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld_i |=> !hit_o);

    // R8
    restart_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i || pat_we_i) |=> (!hit_o && !first_vld_o && cand_hits_o == '0));

    // R5
    lowest_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (diff < POS_W'(NOFS)) && cand_hits_o[diff_ofs]
                  && ((cand_hits_o & below_mask) == '0));

    // R6
    hit_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (cand_hits_o != '0));

    // R7
    first_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (first_vld_o && !clr_i && !pat_we_i) |=> (first_vld_o && $stable(first_pos_o)));

    // R7
    first_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(first_vld_o) |-> (hit_o && first_pos_o == hit_pos_o));

endmodule

bind bws_word_finder bws_chk #(
    .PAT_W  (PAT_W),
    .LANE_W (LANE_W),
    .POS_W  (POS_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (clr_i),
    .pat_we_i    (pat_we_i),
    .byte_vld_i  (byte_vld_i),
    .hit_o       (hit_o),
    .hit_pos_o   (hit_pos_o),
    .cand_base_o (cand_base_o),
    .cand_hits_o (cand_hits_o),
    .first_vld_o (first_vld_o),
    .first_pos_o (first_pos_o)
);

// File: tb/bws_word_finder_tb_top.sv
`timescale 1ns/1ps
module bws_word_finder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_i = 1'b0;
    logic        pat_we_i = 1'b0;
    logic [15:0] pat_i = '0;
    logic        byte_vld_i = 1'b0;
    logic [7:0]  byte_i = '0;
    logic        hit_o;
    logic [31:0] hit_pos_o;
    logic [31:0] cand_base_o;
    logic [7:0]  cand_hits_o;
    logic        first_vld_o;
    logic [31:0] first_pos_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    bws_word_finder dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr_i),
        .pat_we_i    (pat_we_i),
        .pat_i       (pat_i),
        .byte_vld_i  (byte_vld_i),
        .byte_i      (byte_i),
        .hit_o       (hit_o),
        .hit_pos_o   (hit_pos_o),
        .cand_base_o (cand_base_o),
        .cand_hits_o (cand_hits_o),
        .first_vld_o (first_vld_o),
        .first_pos_o (first_pos_o)
    );

    // Stream vectors: 4 bytes, LSB of the word is stream bit 0
    typedef struct packed {
        logic [15:0] pat;
        logic [31:0] stream;
        logic        exp_hit;
        logic [31:0] exp_pos;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{16'hA5C3, 32'h0000A5C3, 1'b1, 32'd0},
        '{16'hA5C3, 32'h00052E18, 1'b1, 32'd3},
        '{16'hA5C3, 32'h0052E180, 1'b1, 32'd7},
        '{16'hA5C3, 32'h00A5C300, 1'b1, 32'd8},
        '{16'hA5C3, 32'h14B86000, 1'b1, 32'd13},
        '{16'hA5C3, 32'h52E18000, 1'b1, 32'd15},
        '{16'hA5C3, 32'h00000000, 1'b0, 32'd0},
        '{16'hFFFF, 32'hFFFFFFFF, 1'b1, 32'd0},
        '{16'h0001, 32'h00000100, 1'b1, 32'd8},
        '{16'h00FF, 32'h0000FF00, 1'b1, 32'd8}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        byte_vld_i = 1'b1;
        byte_i     = b;
        @(negedge clk);
        byte_vld_i = 1'b0;
    endtask

    task automatic load_pat(input logic [15:0] p);
        @(negedge clk);
        pat_we_i = 1'b1;
        pat_i    = p;
        @(negedge clk);
        pat_we_i = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 hit", 32'(hit_o), 32'd0);
        check("R1 first_vld", 32'(first_vld_o), 32'd0);
        check("R1 cand_hits", 32'(cand_hits_o), 32'd0);

        // Table walk: R3 bit order, R4 any offset, R5 lowest wins, R7 sticky
        for (int v = 0; v < NVEC; v++) begin
            load_pat(VECS[v].pat);
            for (int k = 0; k < 4; k++) begin
                send_byte(VECS[v].stream[8*k +: 8]);
            end
            check($sformatf("R3 R4 vec%0d first_vld", v), 32'(first_vld_o), 32'(VECS[v].exp_hit));
            if (VECS[v].exp_hit) begin
                check($sformatf("R5 R7 vec%0d first_pos", v), first_pos_o, VECS[v].exp_pos);
            end
        end

        // R2: no compare before the third byte
        load_pat(16'h0000);
        send_byte(8'h00);
        check("R2 byte0 hit", 32'(hit_o), 32'd0);
        send_byte(8'h00);
        check("R2 byte1 hit", 32'(hit_o), 32'd0);
        send_byte(8'h00);
        check("R4 byte2 hit", 32'(hit_o), 32'd1);
        check("R5 byte2 pos", hit_pos_o, 32'd0);
        check("R6 byte2 mask", 32'(cand_hits_o), 32'hFF);
        check("R6 byte2 base", cand_base_o, 32'd0);
        @(negedge clk);
        check("R4 pulse ends", 32'(hit_o), 32'd0);
        send_byte(8'h00);
        check("R4 byte3 hit", 32'(hit_o), 32'd1);
        check("R5 byte3 pos", hit_pos_o, 32'd8);
        check("R6 byte3 base", cand_base_o, 32'd8);
        check("R7 first held", first_pos_o, 32'd0);

        // R10: unstrobed data is ignored
        @(negedge clk);
        byte_i = 8'hFF;
        repeat (3) @(negedge clk);
        check("R10 idle hit", 32'(hit_o), 32'd0);
        send_byte(8'h00);
        check("R10 pos after idle", hit_pos_o, 32'd16);
        check("R10 mask after idle", 32'(cand_hits_o), 32'hFF);

        // R8: clear restarts numbering and the fill count
        pulse_clr();
        check("R8 first_vld", 32'(first_vld_o), 32'd0);
        check("R8 hit", 32'(hit_o), 32'd0);
        send_byte(8'h00);
        send_byte(8'h00);
        check("R8 R2 no early hit", 32'(hit_o), 32'd0);
        send_byte(8'h00);
        check("R8 pos restart", hit_pos_o, 32'd0);

        // R9: load restarts, new pattern used; partial candidate mask (R6)
        load_pat(16'hFFFF);
        check("R9 first_vld", 32'(first_vld_o), 32'd0);
        send_byte(8'hFF);
        send_byte(8'hFF);
        check("R9 no early hit", 32'(hit_o), 32'd0);
        send_byte(8'h0F);
        check("R9 hit", 32'(hit_o), 32'd1);
        check("R6 partial mask", 32'(cand_hits_o), 32'h1F);
        check("R9 pos", hit_pos_o, 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule